// File: doc/BRIEF.md
# Shared SPI Host Register Front End

This block is the byte-wide register face of an SPI host that more than one processor may drive. A small address window holds the serial clock configuration, a read-only code that reports the frequency of the base clock, a status byte, a data byte and a select number. A processor claims the controller by reading the status byte: if the lock bit comes back clear, that same read takes the lock, so no other agent can also see it clear. The owner drops the lock by writing a one to that bit.

A write to the data byte hands the byte to the shift engine through a one-cycle start pulse and raises the busy flag. When the engine signals completion, the received byte is captured and busy drops, after which the data byte reads back the received value. The select number register picks one active-low select line out of a parameterizable set. The all-ones code, or any number beyond the set, leaves every line high.

Top module: `spi_share_regs`

## Requirements
- R1: During and straight after reset every cs_n line is high, the control byte (0x04) reads 0x0F, the select byte (0x10) reads 0xFF and the status byte (0x08) reads 0x00.
- R2: The byte at 0x03 reads {4'b0, CLK_CODE}, where the code is 0 = 62.5 MHz, 1 = 33.3 MHz, 2 = 125 MHz, 3 = 50 MHz and 4 = 100 MHz. A write there changes nothing.
- R3: Status bit 0 is the lock. A status read returns the value the lock had before the read, and the lock is set from the next cycle, so every later read returns bit 0 = 1.
- R4: A status write with bit 0 = 1 clears the lock. If a status read falls in the same cycle, the release wins. A status write with bit 0 = 0 leaves the lock unchanged.
- R5: A data write (0x0C) while idle drives eng_start high for exactly one cycle, starting the cycle after the write, with eng_tx equal to the written byte. Status bit 1 (busy) is 1 from that cycle on.
- R6: eng_done while busy clears busy in the next cycle and captures eng_rx. The data byte then reads the captured value.
- R7: A data write while busy is 1 is ignored. This includes the cycle in which eng_done arrives: no start pulse follows and eng_tx keeps its value.
- R8: A control write stores bits 5:0: cfg_div = bits 3:0, cfg_cpha = bit 4, cfg_cpol = bit 5. Bits 7:6 read as 0.
- R9: The select byte reads back what was written. For a value n < NUM_CS only cs_n[n] is low. For 0xFF, or any value >= NUM_CS, all lines are high. At most one line is ever low.
- R10: Any other address reads 0x00, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 5 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| eng_start | output | 1 | One-cycle request to the shift engine |
| eng_tx | output | 8 | Byte to shift out |
| eng_done | input | 1 | Shift engine finished the byte |
| eng_rx | input | 8 | Byte shifted in, valid with eng_done |
| cfg_div | output | 4 | Clock divider code |
| cfg_cpha | output | 1 | Clock phase select |
| cfg_cpol | output | 1 | Clock idle level select |
| cs_n | output | NUM_CS | Active-low select lines |

## Verification
Two events can coincide: the engine's completion and a new data write. The bench raises eng_done and a data write in the same cycle. It judges the result by three things: no start pulse follows, eng_tx keeps the old byte, and the data byte returns the byte captured at completion. A lock release written in the same cycle as a status read is the second pairing. The checker requires that the release wins.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] ADDR_CLKCODE = 5'h03;
    localparam logic [ADDR_W-1:0] ADDR_CTRL    = 5'h04;
    localparam logic [ADDR_W-1:0] ADDR_STAT    = 5'h08;
    localparam logic [ADDR_W-1:0] ADDR_DATA    = 5'h0C;
    localparam logic [ADDR_W-1:0] ADDR_CSEL    = 5'h10;

    localparam logic [7:0] CSEL_NONE  = 8'hFF;
    localparam logic [5:0] CTRL_RESET = 6'h0F;

    typedef struct packed {
        logic [5:0] ctrl;
        logic [7:0] csel;
        logic       busy;
        logic       start;
        logic [7:0] tx;
        logic [7:0] rx;
    } regs_t;
endpackage

// File: rtl/spi_regs_lock.sv
module spi_regs_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic acquire,
    input  logic release_req,
    output logic locked
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (acquire)     lock_d = 1'b1;
        if (release_req) lock_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_d;
    end

    assign locked = lock_q;
endmodule

// File: rtl/spi_regs_csdec.sv
module spi_regs_csdec #(
    parameter int NUM_CS = 8
) (
    input  logic              rst_n,
    input  logic [7:0]        sel,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int LIMIT = (NUM_CS > 255) ? 255 : NUM_CS;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        if (i < LIMIT) begin : g_live
            assign cs_n[i] = ~(rst_n && (sel == 8'(i)));
        end else begin : g_dead
            assign cs_n[i] = 1'b1;
        end
    end
endmodule

// File: rtl/spi_share_regs.sv
module spi_share_regs
    import spi_regs_pkg::*;
#(
    parameter int         NUM_CS   = 8,
    parameter logic [3:0] CLK_CODE = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              eng_start,
    output logic [7:0]        eng_tx,
    input  logic              eng_done,
    input  logic [7:0]        eng_rx,
    output logic [3:0]        cfg_div,
    output logic              cfg_cpha,
    output logic              cfg_cpol,
    output logic [NUM_CS-1:0] cs_n
);
    regs_t st_d, st_q;
    logic  lock_q;
    logic  busy_q;
    logic  hit_clk, hit_ctrl, hit_stat, hit_data, hit_csel;
    logic  stat_acquire, stat_release;

    assign hit_clk  = (bus_addr == ADDR_CLKCODE);
    assign hit_ctrl = (bus_addr == ADDR_CTRL);
    assign hit_stat = (bus_addr == ADDR_STAT);
    assign hit_data = (bus_addr == ADDR_DATA);
    assign hit_csel = (bus_addr == ADDR_CSEL);

    assign stat_acquire = bus_rd && hit_stat;
    assign stat_release = bus_wr && hit_stat && bus_wdata[0];

    spi_regs_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .acquire     (stat_acquire),
        .release_req (stat_release),
        .locked      (lock_q)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (bus_wr && hit_ctrl) st_d.ctrl = bus_wdata[5:0];
        if (bus_wr && hit_csel) st_d.csel = bus_wdata;
        if (eng_done && st_q.busy) begin
            st_d.busy = 1'b0;
            st_d.rx   = eng_rx;
        end
        if (bus_wr && hit_data && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.start = 1'b1;
            st_d.tx    = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RESET;
            st_q.csel  <= CSEL_NONE;
            st_q.busy  <= 1'b0;
            st_q.start <= 1'b0;
            st_q.tx    <= 8'h00;
            st_q.rx    <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (hit_clk)  bus_rdata = {4'b0000, CLK_CODE};
        if (hit_ctrl) bus_rdata = {2'b00, st_q.ctrl};
        if (hit_stat) bus_rdata = {6'b0, st_q.busy, lock_q};
        if (hit_data) bus_rdata = st_q.rx;
        if (hit_csel) bus_rdata = st_q.csel;
    end

    assign busy_q    = st_q.busy;
    assign eng_start = st_q.start;
    assign eng_tx    = st_q.tx;
    assign cfg_div   = st_q.ctrl[3:0];
    assign cfg_cpha  = st_q.ctrl[4];
    assign cfg_cpol  = st_q.ctrl[5];

    spi_regs_csdec #(.NUM_CS(NUM_CS)) u_csdec (
        .rst_n (rst_n),
        .sel   (st_q.csel),
        .cs_n  (cs_n)
    );
endmodule

// File: rtl/spi_share_regs_chk.sv
module spi_share_regs_chk
    import spi_regs_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [7:0]        bus_wdata,
    input logic              eng_start,
    input logic              eng_done,
    input logic              busy_q,
    input logic              lock_q,
    input logic [NUM_CS-1:0] cs_n
);
    logic rel_now;
    assign rel_now = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0];

    always_comb begin
        if (!rst_n) assert_cs_high_in_reset_R1: assert (&cs_n);
    end

    assert_lock_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STAT && !rel_now) |=> lock_q);

    assert_lock_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rel_now |=> !lock_q);

    assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> busy_q);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && busy_q) |=> !busy_q);

    assert_busy_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA && busy_q) |=> !eng_start);

    assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);
endmodule

bind spi_share_regs spi_share_regs_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .busy_q    (busy_q),
    .lock_q    (lock_q),
    .cs_n      (cs_n)
);

// File: tb/spi_share_regs_test.sv
module spi_share_regs_test;
    localparam int NCS = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [4:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic           eng_start;
    logic [7:0]     eng_tx;
    logic           eng_done = 1'b0;
    logic [7:0]     eng_rx = '0;
    logic [3:0]     cfg_div;
    logic           cfg_cpha, cfg_cpol;
    logic [NCS-1:0] cs_n;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    spi_share_regs #(.NUM_CS(NCS), .CLK_CODE(4'h4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done),
        .eng_rx(eng_rx), .cfg_div(cfg_div), .cfg_cpha(cfg_cpha),
        .cfg_cpol(cfg_cpol), .cs_n(cs_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_byte(input logic [7:0] r);
        @(negedge clk);
        eng_done = 1'b1; eng_rx = r;
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 cs_n in reset", 32'(cs_n), 32'(8'hFF));
        @(negedge clk); rst_n = 1'b1;
        rd(5'h04, v); check("R1 control", 32'(v), 32'h0F);
        rd(5'h10, v); check("R1 select", 32'(v), 32'hFF);
        check("R1 cs_n", 32'(cs_n), 32'(8'hFF));
        check("R1 cfg_div", 32'(cfg_div), 32'hF);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        rd(5'h08, v); check("R1/R3 first status read", 32'(v), 32'h00);
        rd(5'h08, v); check("R3 second read", 32'(v), 32'h01);
        wr(5'h08, 8'h00);
        rd(5'h08, v); check("R4 write 0 keeps lock", 32'(v), 32'h01);
        wr(5'h08, 8'h01);
        rd(5'h08, v); check("R4 released", 32'(v), 32'h00);
        rd(5'h08, v); check("R3 retaken", 32'(v), 32'h01);
        @(negedge clk);
        bus_addr = 5'h08; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        rd(5'h08, v); check("R4 release beats read", 32'(v), 32'h00);
        wr(5'h08, 8'h01);
    endtask

    task automatic t_clkcode();
        logic [7:0] v;
        rd(5'h03, v); check("R2 clock code", 32'(v), 32'h04);
        wr(5'h03, 8'hAA);
        rd(5'h03, v); check("R2 write ignored", 32'(v), 32'h04);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(5'h04, 8'hF5);
        rd(5'h04, v); check("R8 control readback", 32'(v), 32'h35);
        check("R8 cfg fields", 32'({cfg_cpol, cfg_cpha, cfg_div}), 32'h35);
    endtask

    task automatic t_xfer();
        logic [7:0] v;
        wr(5'h0C, 8'h3C);
        check("R5 start pulse", 32'(eng_start), 32'h1);
        check("R5 tx byte", 32'(eng_tx), 32'h3C);
        rd(5'h08, v); check("R5 busy set", 32'(v[1]), 32'h1);
        check("R5 pulse one cycle", 32'(eng_start), 32'h0);
        wr(5'h0C, 8'h77);
        check("R7 no start when busy", 32'(eng_start), 32'h0);
        check("R7 tx kept", 32'(eng_tx), 32'h3C);
        finish_byte(8'hC3);
        rd(5'h08, v); check("R6 busy cleared", 32'(v[1]), 32'h0);
        rd(5'h0C, v); check("R6 rx byte", 32'(v), 32'hC3);
        wr(5'h08, 8'h01);
    endtask

    task automatic t_overlap();
        logic [7:0] v;
        wr(5'h0C, 8'h11);
        @(negedge clk);
        bus_addr = 5'h0C; bus_wdata = 8'h99; bus_wr = 1'b1;
        eng_done = 1'b1; eng_rx = 8'h5A;
        @(negedge clk);
        bus_wr = 1'b0; eng_done = 1'b0;
        check("R7 done+write no start", 32'(eng_start), 32'h0);
        check("R7 done+write tx kept", 32'(eng_tx), 32'h11);
        rd(5'h0C, v); check("R6 rx on overlap", 32'(v), 32'h5A);
        wr(5'h0C, 8'h22);
        check("R5 restart after overlap", 32'({eng_start, eng_tx}), 32'h122);
        finish_byte(8'h00);
    endtask

    task automatic t_select();
        logic [7:0] v;
        wr(5'h10, 8'h03);
        check("R9 line 3 low", 32'(cs_n), 32'(8'hF7));
        rd(5'h10, v); check("R9 readback", 32'(v), 32'h03);
        wr(5'h10, 8'h00);
        check("R9 line 0 low", 32'(cs_n), 32'(8'hFE));
        wr(5'h10, 8'(NCS));
        check("R9 out of range none", 32'(cs_n), 32'(8'hFF));
        wr(5'h10, 8'h07);
        check("R9 top line low", 32'(cs_n), 32'(8'h7F));
        wr(5'h10, 8'hFF);
        check("R9 none code", 32'(cs_n), 32'(8'hFF));
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        wr(5'h05, 8'hFF);
        rd(5'h05, v); check("R10 unmapped reads 0", 32'(v), 32'h00);
        rd(5'h04, v); check("R10 control untouched", 32'(v), 32'h35);
        check("R10 cs untouched", 32'(cs_n), 32'(8'hFF));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_lock();
        t_clkcode();
        t_ctrl();
        t_xfer();
        t_overlap();
        t_select();
        t_unmapped();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule